// File: doc/BRIEF.md
# Half/Full-Duplex Nibble Transmit MAC

This block is the transmit half of a 10/100 Ethernet media access controller. It collects one frame from a byte-wide valid/ready source into a local frame store. It then drives the frame onto a 4-bit media-independent transmit interface, led by a preamble and a start-of-frame delimiter. Speed is set entirely by the transmit clock the PHY supplies: one nibble per clock at 25 MHz gives 100 Mbps, and at 2.5 MHz gives 10 Mbps. The frame check sequence is expected to arrive already appended to the payload bytes.

The `full_duplex` input can change at any time and is looked at on every clock. With it low, the engine follows carrier-sense multiple access with collision detection. It waits for an idle medium and a full inter-frame gap, and watches the collision input while sending. On a collision it emits a jam, waits a pseudo-random number of slot times, and sends the whole frame again from the preamble. The frame is abandoned after a set number of collisions. With `full_duplex` high, carrier and collision have no effect and each frame goes out after the gap alone.

Because the frame is held locally, a retry replays the stored bytes and needs nothing from the source. The source can offer the next frame only once the current one has been sent or dropped.

Top module: `mii_tx_mac`

## Requirements
- R1: After reset `in_ready`=1, `tx_en`=0, `txd`=0 and `excess_col`=0. While `in_ready` is high, every clock with `in_valid` high stores one byte. The frame closes on the byte that carries `in_last`, or on byte number DEPTH. From the clock after that, `in_ready` stays low until the frame has been sent or dropped.
- R2: Each attempt opens with `tx_en` rising and `txd` carrying 15 nibbles of 0x5 and then one nibble of 0xD. These are 14 preamble nibbles plus the delimiter nibbles 0x5, 0xD.
- R3: Payload bytes follow in order, low nibble first. `tx_en` stays high without a gap through the last nibble and falls on the next clock. Whenever `tx_en` is low, `txd` is 0.
- R4: An attempt starts only after IFG_NIBBLES consecutive clocks in the waiting state with (`full_duplex`=1 or `crs`=0). In half duplex, any clock with `crs`=1 restarts that count. This waiting also comes after loading a frame and after every backoff.
- R5: In half duplex, `col`=1 on any clock of an attempt (preamble, delimiter or data) ends the attempt. The next JAM_NIBBLES clocks carry `tx_en`=1 and `txd`=JAM_VALUE (default 0x9).
- R6: After jam number n of a frame, slots = the low min(n, BACKOFF_CAP) bits of a 16-bit register, read during the last jam nibble. That register is loaded with 0xACE1 at reset and shifts left on every clock, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10. `tx_en` then stays low for slots*SLOT_NIBBLES+1 clocks, the R4 wait follows, and the whole frame is sent again from the preamble.
- R7: The jam that ends collision number MAX_ATTEMPTS drops the frame. On the clock after it, `excess_col` is 1 for exactly one clock and `in_ready` is 1.
- R8: With `full_duplex`=1, `crs` and `col` have no effect. A frame of L bytes is sent exactly once, with `tx_en` high for 16+2L clocks.
- R9: `full_duplex` is sampled on every clock. Lowering it during an attempt while `col`=1 starts the jam on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY (2.5 or 25 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_duplex | input | 1 | 1 = unconditional sending, 0 = collision-detect rules |
| crs | input | 1 | Carrier present on the medium |
| col | input | 1 | Collision reported by the PHY |
| in_data | input | 8 | Frame byte from the source |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | This byte ends the frame |
| in_ready | output | 1 | Block accepts a byte this clock |
| txd | output | 4 | Transmit nibble toward the PHY |
| tx_en | output | 1 | Transmit enable toward the PHY |
| excess_col | output | 1 | One-clock pulse when a frame is dropped after too many collisions |

## Verification
The bound checker covers the rules that hold on every clock:
- `txd` is quiet while `tx_en` is low.
- `in_ready` is never high during transmission.
- A half-duplex collision during an attempt always leads to the jam value on the next clock, and full duplex never enters a jam.
- Every attempt starts with a 0x5 nibble.
- Carrier during the wait holds `tx_en` low.
- The drop flag is a single-clock pulse seen only with `in_ready` high.

Other behaviour needs the bench's cycle-by-cycle reference model and its scenarios:
- the exact backoff lengths drawn from the pseudo-random register;
- the restart of the gap count by carrier;
- replay of the stored bytes on each retry;
- the drop after the final allowed collision;
- a frame closed by a full store;
- a duplex change in the middle of a frame.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

   typedef enum logic [2:0] {
      ST_LOAD    = 3'd0,
      ST_DEFER   = 3'd1,
      ST_TX      = 3'd2,
      ST_JAM     = 3'd3,
      ST_BACKOFF = 3'd4
   } tx_state_e;

   localparam logic [3:0] NIB_PRE   = 4'h5;
   localparam logic [3:0] NIB_SFD   = 4'hD;
   localparam int         HDR_NIBS  = 16;

endpackage

// File: rtl/mii_tx_lfsr.sv
module mii_tx_lfsr #(
   parameter int             W     = 16,
   parameter int             OUT_W = 10,
   parameter logic [W-1:0]   SEED  = W'(16'hACE1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);

   logic [W-1:0] q;
   logic         fb;

   generate
      if (W == 16) begin : g_taps16
         assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];
      end else if (W == 32) begin : g_taps32
         assign fb = q[31] ^ q[21] ^ q[1] ^ q[0];
      end else begin : g_bad_w
         $error("mii_tx_lfsr: W must be 16 or 32");
      end
      if (OUT_W > W) begin : g_bad_out
         $error("mii_tx_lfsr: OUT_W exceeds W");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("mii_tx_lfsr: SEED must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= SEED;
      else        q <= {q[W-2:0], fb};
   end

   assign rnd = q[OUT_W-1:0];

endmodule

// File: rtl/mii_tx_framebuf.sv
module mii_tx_framebuf #(
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/mii_tx_backoff.sv
module mii_tx_backoff #(
   parameter int  SLOT_NIBBLES = 128,
   parameter int  CAP          = 10,
   parameter int  ATT_W        = 5,
   localparam int REM_W        = CAP + $clog2(SLOT_NIBBLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ATT_W-1:0] collisions,
   input  logic [CAP-1:0]   rnd,
   output logic             expired
);

   logic [CAP-1:0]   mask;
   logic [CAP-1:0]   slots;
   logic [REM_W-1:0] rem;

   // one mask bit per possible exponent step: bit i opens once n > i
   generate
      for (genvar i = 0; i < CAP; i++) begin : g_mask
         assign mask[i] = (32'(collisions) > i);
      end
   endgenerate

   assign slots = rnd & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             rem <= '0;
      else if (load)          rem <= REM_W'(slots) * REM_W'(SLOT_NIBBLES);
      else if (rem != '0)     rem <= rem - REM_W'(1);
   end

   assign expired = (rem == '0);

endmodule

// File: rtl/mii_tx_mac.sv
module mii_tx_mac
   import mii_tx_pkg::*;
#(
   parameter int          DEPTH        = 128,
   parameter int          IFG_NIBBLES  = 24,
   parameter int          JAM_NIBBLES  = 8,
   parameter logic [3:0]  JAM_VALUE    = 4'h9,
   parameter int          SLOT_NIBBLES = 128,
   parameter int          BACKOFF_CAP  = 10,
   parameter int          MAX_ATTEMPTS = 16,
   parameter int          LFSR_W       = 16,
   parameter logic [31:0] LFSR_SEED    = 32'h0000ACE1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       full_duplex,
   input  logic       crs,
   input  logic       col,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   input  logic       in_last,
   output logic       in_ready,
   output logic [3:0] txd,
   output logic       tx_en,
   output logic       excess_col
);

   localparam int AW    = $clog2(DEPTH);
   localparam int LEN_W = AW + 1;
   localparam int POS_W = $clog2(2 * DEPTH + HDR_NIBS);
   localparam int GAP_W = $clog2(IFG_NIBBLES + 1);
   localparam int JAM_W = $clog2(JAM_NIBBLES + 1);
   localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mii_tx_mac: DEPTH must be at least 2");
      end
      if (IFG_NIBBLES < 1 || JAM_NIBBLES < 1 || MAX_ATTEMPTS < 1) begin : g_bad_cnt
         $error("mii_tx_mac: gap, jam and attempt counts must be positive");
      end
      if (BACKOFF_CAP < 1 || BACKOFF_CAP > LFSR_W) begin : g_bad_cap
         $error("mii_tx_mac: BACKOFF_CAP must lie in 1..LFSR_W");
      end
      if (SLOT_NIBBLES < 1) begin : g_bad_slot
         $error("mii_tx_mac: SLOT_NIBBLES must be positive");
      end
   endgenerate

   tx_state_e         state;
   logic [AW-1:0]     wr;
   logic [LEN_W-1:0]  len;
   logic [GAP_W-1:0]  gap;
   logic [POS_W-1:0]  pos;
   logic [JAM_W-1:0]  jcnt;
   logic [ATT_W-1:0]  att;
   logic              exc_q;

   logic              half;
   logic              jam_end;
   logic [POS_W-1:0]  last_pos;
   logic [7:0]        rd_byte;
   logic [BACKOFF_CAP-1:0] rnd;
   logic              bo_expired;

   assign half     = !full_duplex;
   assign jam_end  = (state == ST_JAM) && (jcnt == JAM_W'(JAM_NIBBLES - 1));
   assign last_pos = POS_W'({len, 1'b0}) + POS_W'(HDR_NIBS - 1);

   mii_tx_framebuf #(.DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .we    (state == ST_LOAD && in_valid),
      .waddr (wr),
      .wdata (in_data),
      .raddr (AW'((pos - POS_W'(HDR_NIBS)) >> 1)),
      .rdata (rd_byte)
   );

   mii_tx_lfsr #(
      .W     (LFSR_W),
      .OUT_W (BACKOFF_CAP),
      .SEED  (LFSR_W'(LFSR_SEED))
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   mii_tx_backoff #(
      .SLOT_NIBBLES (SLOT_NIBBLES),
      .CAP          (BACKOFF_CAP),
      .ATT_W        (ATT_W)
   ) u_backoff (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (jam_end),
      .collisions (att + ATT_W'(1)),
      .rnd        (rnd),
      .expired    (bo_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_LOAD;
         wr    <= '0;
         len   <= '0;
         gap   <= '0;
         pos   <= '0;
         jcnt  <= '0;
         att   <= '0;
         exc_q <= 1'b0;
      end else begin
         exc_q <= 1'b0;
         unique case (state)
            ST_LOAD: begin
               if (in_valid) begin
                  if (in_last || wr == AW'(DEPTH - 1)) begin
                     len   <= LEN_W'(wr) + LEN_W'(1);
                     wr    <= '0;
                     gap   <= '0;
                     att   <= '0;
                     state <= ST_DEFER;
                  end else begin
                     wr <= wr + AW'(1);
                  end
               end
            end
            ST_DEFER: begin
               if (half && crs) begin
                  gap <= '0;
               end else if (gap == GAP_W'(IFG_NIBBLES - 1)) begin
                  pos   <= '0;
                  state <= ST_TX;
               end else begin
                  gap <= gap + GAP_W'(1);
               end
            end
            ST_TX: begin
               if (half && col) begin
                  jcnt  <= '0;
                  state <= ST_JAM;
               end else if (pos == last_pos) begin
                  state <= ST_LOAD;
               end else begin
                  pos <= pos + POS_W'(1);
               end
            end
            ST_JAM: begin
               if (jam_end) begin
                  att <= att + ATT_W'(1);
                  if (att + ATT_W'(1) == ATT_W'(MAX_ATTEMPTS)) begin
                     exc_q <= 1'b1;
                     state <= ST_LOAD;
                  end else begin
                     state <= ST_BACKOFF;
                  end
               end else begin
                  jcnt <= jcnt + JAM_W'(1);
               end
            end
            ST_BACKOFF: begin
               if (bo_expired) begin
                  gap   <= '0;
                  state <= ST_DEFER;
               end
            end
            default: state <= ST_LOAD;
         endcase
      end
   end

   always_comb begin
      txd = 4'h0;
      if (state == ST_TX) begin
         if (pos < POS_W'(HDR_NIBS - 1))       txd = NIB_PRE;
         else if (pos == POS_W'(HDR_NIBS - 1)) txd = NIB_SFD;
         else if (!pos[0])                     txd = rd_byte[3:0];
         else                                  txd = rd_byte[7:4];
      end else if (state == ST_JAM) begin
         txd = JAM_VALUE;
      end
   end

   assign tx_en      = (state == ST_TX) || (state == ST_JAM);
   assign in_ready   = (state == ST_LOAD);
   assign excess_col = exc_q;

endmodule

module mii_tx_mac_chk
   import mii_tx_pkg::*;
#(
   parameter logic [3:0] JAM_VALUE = 4'h9
) (
   input logic       clk,
   input logic       rst_n,
   input logic       full_duplex,
   input logic       crs,
   input logic       col,
   input logic       in_ready,
   input logic [3:0] txd,
   input logic       tx_en,
   input logic       excess_col,
   input tx_state_e  state
);

   p_txd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> txd == 4'h0);

   p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !tx_en);

   p_preamble_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> txd == 4'h5);

   p_defer_crs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEFER && !full_duplex && crs) |=> !tx_en);

   p_jam_on_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX && !full_duplex && col) |=> (tx_en && txd == JAM_VALUE));

   p_exc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      excess_col |=> !excess_col);

   p_exc_after_jam_r7: assert property (@(posedge clk) disable iff (!rst_n)
      excess_col |-> (in_ready && $past(tx_en)));

   p_fd_no_jam_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX && full_duplex) |=> state != ST_JAM);

endmodule

bind mii_tx_mac mii_tx_mac_chk #(.JAM_VALUE(JAM_VALUE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .full_duplex (full_duplex),
   .crs         (crs),
   .col         (col),
   .in_ready    (in_ready),
   .txd         (txd),
   .tx_en       (tx_en),
   .excess_col  (excess_col),
   .state       (state)
);

// File: tb/tb_mii_tx_mac.sv
`timescale 1ns/1ps
module tb_mii_tx_mac;

   localparam int         DEPTH = 32;
   localparam int         IFG   = 24;
   localparam int         JAMN  = 8;
   localparam logic [3:0] JAMV  = 4'h9;
   localparam int         SLOT  = 8;
   localparam int         CAP   = 10;
   localparam int         MAXA  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       full_duplex = 1'b0;
   logic       crs = 1'b0;
   logic       col = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic [3:0] txd;
   logic       tx_en;
   logic       excess_col;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mii_tx_mac #(
      .DEPTH(DEPTH), .IFG_NIBBLES(IFG), .JAM_NIBBLES(JAMN), .JAM_VALUE(JAMV),
      .SLOT_NIBBLES(SLOT), .BACKOFF_CAP(CAP), .MAX_ATTEMPTS(MAXA)
   ) dut (
      .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs(crs), .col(col),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .txd(txd), .tx_en(tx_en), .excess_col(excess_col)
   );

   // ---------------- reference model (phases: 0 load,1 wait,2 send,3 jam,4 backoff)
   int         m_ph, m_wr, m_len, m_g, m_pos, m_j, m_att, m_rem;
   bit         m_exc;
   logic [15:0] m_rng;
   logic [7:0] m_buf [DEPTH];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_wr = 0; m_len = 0; m_g = 0; m_pos = 0; m_j = 0;
         m_att = 0; m_rem = 0; m_exc = 0; m_rng = 16'hACE1;
      end else begin
         bit exc_n;
         exc_n = 0;
         case (m_ph)
            0: if (in_valid) begin
                  m_buf[m_wr] = in_data;
                  if (in_last || m_wr == DEPTH - 1) begin
                     m_len = m_wr + 1; m_wr = 0; m_g = 0; m_att = 0; m_ph = 1;
                  end else m_wr++;
               end
            1: if (!full_duplex && crs) m_g = 0;
               else if (m_g == IFG - 1) begin m_ph = 2; m_pos = 0; end
               else m_g++;
            2: if (!full_duplex && col) begin m_ph = 3; m_j = 0; end
               else if (m_pos == 2 * m_len + 15) m_ph = 0;
               else m_pos++;
            3: if (m_j == JAMN - 1) begin
                  m_att++;
                  if (m_att == MAXA) begin m_ph = 0; exc_n = 1; end
                  else begin
                     int k;
                     k = (m_att < CAP) ? m_att : CAP;
                     m_rem = (int'(m_rng) & ((1 << k) - 1)) * SLOT;
                     m_ph = 4;
                  end
               end else m_j++;
            default: if (m_rem == 0) begin m_ph = 1; m_g = 0; end
                     else m_rem--;
         endcase
         m_exc = exc_n;
         m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
      end
   end

   function automatic logic [3:0] exp_txd();
      if (m_ph == 2) begin
         if (m_pos < 15)  return 4'h5;
         if (m_pos == 15) return 4'hD;
         if ((m_pos % 2) == 0) return m_buf[(m_pos - 16) / 2][3:0];
         return m_buf[(m_pos - 16) / 2][7:4];
      end
      if (m_ph == 3) return JAMV;
      return 4'h0;
   endfunction

   function automatic string ph_tag();
      case (m_ph)
         0: return "R1";
         1: return "R4";
         2: return (m_pos < 16) ? "R2" : "R3";
         3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s t=%0t act=%0h exp=%0h", tag, $time, act, exp);
      end
   endtask

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(in_ready === (m_ph == 0), {ph_tag(), " in_ready"}, in_ready, m_ph == 0);
         chk(tx_en === (m_ph == 2 || m_ph == 3), {ph_tag(), " tx_en"}, tx_en, m_ph == 2 || m_ph == 3);
         chk(txd === exp_txd(), {ph_tag(), " txd"}, txd, exp_txd());
         chk(excess_col === m_exc, "R7 excess_col", excess_col, m_exc);
      end
   end

   // observation counters at the ports
   int  en_cycles, en_rises, exc_seen;
   bit  prev_en = 0;
   always @(negedge clk) begin
      if (tx_en) en_cycles++;
      if (tx_en && !prev_en) en_rises++;
      if (excess_col) exc_seen++;
      prev_en = tx_en;
   end

   // collision stimulus: 0 off, 1 at one nibble position (budgeted), 2 held high
   int col_mode = 0, col_at = 0, col_left = 0;
   always @(negedge clk) begin
      if (col_mode == 2) col = 1'b1;
      else if (col_mode == 1 && col_left > 0 && m_ph == 2 && m_pos == col_at && !full_duplex) begin
         col = 1'b1; col_left--;
      end else col = 1'b0;
   end

   task automatic clear_obs();
      en_cycles = 0; en_rises = 0; exc_seen = 0;
   endtask

   task automatic send(input int n, input int base, input bit use_last);
      while (!(m_ph == 0 && in_ready)) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_data  = 8'(base + 7 * i);
         in_last  = use_last && (i == n - 1);
         @(negedge clk);
      end
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_ph != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk(in_ready === 1'b1, "R1 reset in_ready", in_ready, 1);
      chk(tx_en === 1'b0, "R1 reset tx_en", tx_en, 0);
      chk(txd === 4'h0, "R1 reset txd", txd, 0);
      chk(excess_col === 1'b0, "R1 reset excess_col", excess_col, 0);

      // R8: full duplex ignores carrier and collision
      full_duplex = 1; crs = 1; col_mode = 2; clear_obs();
      send(6, 8'h31, 1);
      wait_idle();
      chk(en_cycles == 28, "R8 single attempt length", en_cycles, 28);
      chk(en_rises == 1, "R8 one attempt", en_rises, 1);
      col_mode = 0; crs = 0;

      // R4: carrier holds off the start, a short burst restarts the gap
      full_duplex = 0; crs = 1; clear_obs();
      send(4, 8'hA0, 1);
      repeat (40) @(negedge clk);
      chk(en_cycles == 0, "R4 held by carrier", en_cycles, 0);
      crs = 0; repeat (10) @(negedge clk);
      crs = 1; @(negedge clk); crs = 0;
      wait_idle();
      chk(en_rises == 1, "R4 sent once", en_rises, 1);

      // R5 R6: two collisions then success, frame replayed from preamble
      col_mode = 1; col_at = 20; col_left = 2; clear_obs();
      send(10, 8'h5C, 1);
      wait_idle();
      chk(en_rises == 3, "R6 retries", en_rises, 3);
      chk(exc_seen == 0, "R6 no drop", exc_seen, 0);

      // R5 during delimiter and preamble positions
      col_mode = 1; col_at = 15; col_left = 1; clear_obs();
      send(3, 8'h11, 1);
      wait_idle();
      chk(en_rises == 2, "R5 collision on delimiter", en_rises, 2);

      // R7: every attempt collides, frame dropped after MAXA
      col_mode = 1; col_at = 17; col_left = 1000; clear_obs();
      send(3, 8'hE4, 1);
      wait_idle();
      chk(en_rises == MAXA, "R7 attempt count", en_rises, MAXA);
      chk(exc_seen == 1, "R7 one drop pulse", exc_seen, 1);
      col_mode = 0; clear_obs();
      send(5, 8'h02, 1);
      wait_idle();
      chk(exc_seen == 0 && en_rises == 1, "R7 next frame normal", en_rises, 1);

      // R9: switch to half duplex mid-frame while collision is high
      full_duplex = 1; col_mode = 2; clear_obs();
      send(8, 8'h77, 1);
      while (!(m_ph == 2 && m_pos == 30)) @(negedge clk);
      full_duplex = 0;
      @(negedge clk);
      col_mode = 0;
      wait_idle();
      chk(en_rises == 2, "R9 duplex change jams", en_rises, 2);

      // R1: store fills without last marker
      clear_obs();
      send(DEPTH, 8'h40, 0);
      chk(in_ready === 1'b0, "R1 full store closes frame", in_ready, 0);
      wait_idle();
      chk(en_cycles == 16 + 2 * DEPTH, "R1 R3 full frame length", en_cycles, 16 + 2 * DEPTH);

      repeat (5) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule